// File: doc/BRIEF.md
# Serial Memory Write-Protect Arbiter

This block sits between the command decoder of a 256-byte two-wire serial memory and its storage array. For every write request it decides two things: whether the memory should acknowledge the request at byte level, and whether the array's internal write enable may fire. It combines two protection sources. One is a level-sensitive protect pin. The other is a one-time programmable protection flag that, once set, locks the lower half of the array.

The flag is programmed through a separate device-type code carried by an ordinary byte-write request. It can be programmed only once. After that, every request that carries this code is refused. The flag models non-volatile storage, so the functional reset does not clear it. Only a power-on initialisation input clears it, and that input exists only for simulation.

A request is a one-cycle strobe with the device-type nibble, the byte address and the protect-pin level sampled at the same clock edge. The decision is registered and appears on the outputs one cycle later. The pin is a plain level, so there is no back-pressure: every strobe is answered in the following cycle. A floating protect pin is assumed to be pulled low outside the block.

Top module: `wp_arbiter`

## Requirements
- R1: With the protect pin high, a request with device type 4'b1010 (array) is acknowledged (`ack_ok`=1) but `wr_en` stays 0, whatever the flag holds.
- R2: With the protect pin high, a request with device type 4'b0110 (protection register) is not acknowledged, and `prot_flag` keeps its value.
- R3: With the pin low and the flag set, an array request to an address 0 to 127 (address bit 7 = 0) is acknowledged with `wr_en`=0.
- R4: With the pin low, an array request to an address 128 to 255 gives `ack_ok`=1 and `wr_en`=1 whatever the flag holds, and any address gives the same result while the flag is clear.
- R5: With the pin low and the flag clear, a type 4'b0110 request is acknowledged and sets `prot_flag`. The new value shows on `prot_flag` in the same cycle as that request's `ack_ok`.
- R6: Once the flag is set, every type 4'b0110 request gets `ack_ok`=0 and `wr_en`=0, and the flag stays set.
- R7: `rst_n` low clears `ack_ok` and `wr_en` but leaves `prot_flag` unchanged. Only `por_init` high clears `prot_flag`.
- R8: A request with any other device type gives `ack_ok`=0 and `wr_en`=0 and leaves the flag unchanged.
- R9: `ack_ok` and `wr_en` reflect the request strobed at the previous rising clock edge, and both are 0 in any cycle that follows a clock edge with no strobe.
- R10: `wr_en` is never 1 while `ack_ok` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous functional reset, active low; does not clear the flag |
| por_init | input | 1 | Power-on initialisation, simulation only; clears everything |
| req_stb | input | 1 | One-cycle write-request strobe |
| dev_type | input | 4 | Decoded device-type nibble of the request |
| byte_addr | input | 8 | Byte address of the request |
| wp_pin | input | 1 | Protect pin level; high blocks all array writes |
| ack_ok | output | 1 | Request may be acknowledged (registered) |
| wr_en | output | 1 | Array write enable (registered) |
| prot_flag | output | 1 | Current one-time protection flag |

## Verification
The embedded properties check several rules on every cycle. A pin-high request never yields a write enable. A locked lower-half address is never written. The flag never falls except under power-on initialisation. A protection-code request after locking is never acknowledged. A write enable never appears without acknowledge. Some behaviours can only be shown by the bench's scenarios:
- the flag surviving a functional reset and being cleared only by power-on initialisation;
- the single successful programming;
- the upper half staying writable after lock;
- unknown device types being refused.

// File: rtl/wp_arbiter_pkg.sv
package wp_arbiter_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_ARRAY = 2'd1,
    TGT_PROT  = 2'd2
  } wp_target_e;
endpackage

// File: rtl/wp_type_decode.sv
module wp_type_decode
  import wp_arbiter_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter logic [TYPE_W-1:0] ARRAY_CODE = 4'b1010,
  parameter logic [TYPE_W-1:0] PROT_CODE  = 4'b0110
) (
  input  logic [TYPE_W-1:0] dev_type,
  output wp_target_e        tgt
);
  always_comb begin
    if (dev_type == ARRAY_CODE)     tgt = TGT_ARRAY;
    else if (dev_type == PROT_CODE) tgt = TGT_PROT;
    else                            tgt = TGT_NONE;
  end
endmodule

// File: rtl/wp_flag_store.sv
module wp_flag_store (
  input  logic clk,
  input  logic por_init,
  input  logic set_req,
  output logic flag
);
  // Models a non-volatile cell: the functional reset is deliberately absent.
  always_ff @(posedge clk) begin
    if (por_init)     flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (por_init)
    flag |=> flag); // R7
endmodule

// File: rtl/wp_grant.sv
module wp_grant
  import wp_arbiter_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LOCK_LIMIT = 2 ** (ADDR_W - 1)
) (
  input  wp_target_e        tgt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wp_pin,
  input  logic              flag,
  output logic              ack_allow,
  output logic              wr_allow,
  output logic              set_flag
);
  localparam logic [ADDR_W-1:0] LIMIT_V = ADDR_W'(LOCK_LIMIT);

  logic in_locked_span;
  assign in_locked_span = (addr < LIMIT_V);

  always_comb begin
    ack_allow = 1'b0;
    wr_allow  = 1'b0;
    set_flag  = 1'b0;
    unique case (tgt)
      TGT_ARRAY: begin
        ack_allow = 1'b1;
        wr_allow  = !wp_pin && !(flag && in_locked_span);
      end
      TGT_PROT: begin
        if (!wp_pin && !flag) begin
          ack_allow = 1'b1;
          set_flag  = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wp_arbiter.sv
module wp_arbiter
  import wp_arbiter_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int ADDR_W = 8,
  parameter logic [TYPE_W-1:0] ARRAY_CODE = 4'b1010,
  parameter logic [TYPE_W-1:0] PROT_CODE  = 4'b0110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_init,
  input  logic              req_stb,
  input  logic [TYPE_W-1:0] dev_type,
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              wp_pin,
  output logic              ack_ok,
  output logic              wr_en,
  output logic              prot_flag
);
  localparam int LOCK_LIMIT = 2 ** (ADDR_W - 1);

  wp_target_e tgt;
  logic ack_c, wr_c, set_c;

  wp_type_decode #(.TYPE_W(TYPE_W), .ARRAY_CODE(ARRAY_CODE), .PROT_CODE(PROT_CODE))
    u_dec (.dev_type(dev_type), .tgt(tgt));

  wp_grant #(.ADDR_W(ADDR_W), .LOCK_LIMIT(LOCK_LIMIT))
    u_grant (.tgt(tgt), .addr(byte_addr), .wp_pin(wp_pin), .flag(prot_flag),
             .ack_allow(ack_c), .wr_allow(wr_c), .set_flag(set_c));

  wp_flag_store u_flag (.clk(clk), .por_init(por_init),
                        .set_req(req_stb && set_c && rst_n), .flag(prot_flag));

  always_ff @(posedge clk) begin
    if (!rst_n || por_init) begin
      ack_ok <= 1'b0;
      wr_en  <= 1'b0;
    end else begin
      ack_ok <= req_stb && ack_c;
      wr_en  <= req_stb && wr_c;
    end
  end

  AST_PIN_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n || por_init)
    (req_stb && wp_pin) |=> !wr_en); // R1
  AST_PIN_NO_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n || por_init)
    (req_stb && wp_pin && dev_type == PROT_CODE) |=> (!ack_ok && prot_flag == $past(prot_flag))); // R2
  AST_LOW_HALF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n || por_init)
    (req_stb && prot_flag && dev_type == ARRAY_CODE && byte_addr < ADDR_W'(LOCK_LIMIT)) |=> !wr_en); // R3
  AST_LOCKED_NACK: assert property (@(posedge clk) disable iff (!rst_n || por_init)
    (req_stb && prot_flag && dev_type == PROT_CODE) |=> !ack_ok); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n || por_init)
    !req_stb |=> (!ack_ok && !wr_en)); // R9
  AST_WREN_NEEDS_ACK: assert property (@(posedge clk) disable iff (por_init)
    wr_en |-> ack_ok); // R10
endmodule

// File: tb/test_wp_arbiter.sv
module test_wp_arbiter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_init = 1'b1;
  logic req_stb = 1'b0;
  logic [3:0] dev_type = 4'h0;
  logic [7:0] byte_addr = 8'h00;
  logic wp_pin = 1'b0;
  logic ack_ok, wr_en, prot_flag;

  int errors = 0;
  int checks = 0;
  logic flag_m = 1'b0;

  typedef struct {
    logic ack;
    logic wr;
    logic flg;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk;

  wp_arbiter i_wp_arbiter (
    .clk(clk), .rst_n(rst_n), .por_init(por_init), .req_stb(req_stb),
    .dev_type(dev_type), .byte_addr(byte_addr), .wp_pin(wp_pin),
    .ack_ok(ack_ok), .wr_en(wr_en), .prot_flag(prot_flag));

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per answered request.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(ack_ok, e.ack, {e.tag, " ack_ok"});
      chk(wr_en, e.wr, {e.tag, " wr_en"});
      chk(prot_flag, e.flg, {e.tag, " prot_flag"});
    end
  end

  // Driver: strobes one request and pushes the independently computed result.
  task automatic send(input logic [3:0] t, input logic [7:0] a, input logic pin, input string tag);
    exp_t e;
    @(negedge clk);
    req_stb = 1'b1; dev_type = t; byte_addr = a; wp_pin = pin;
    e.ack = 1'b0; e.wr = 1'b0; e.tag = tag;
    if (t == 4'b1010) begin
      e.ack = 1'b1;
      e.wr = !pin && !(flag_m && a < 8'd128);
    end else if (t == 4'b0110) begin
      if (!pin && !flag_m) begin
        e.ack = 1'b1;
        flag_m = 1'b1;
      end
    end
    e.flg = flag_m;
    @(posedge clk);
    #1 sb_q.push_back(e);
    req_stb = 1'b0; wp_pin = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    por_init = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ack_ok, 1'b0, "R9 reset ack_ok");
    chk(wr_en, 1'b0, "R9 reset wr_en");
    chk(prot_flag, 1'b0, "R7 reset prot_flag");

    send(4'b1010, 8'h05, 1'b0, "R4 unlocked low addr");
    send(4'b1010, 8'hF0, 1'b0, "R4 unlocked high addr");
    send(4'b1010, 8'h10, 1'b1, "R1 pin high unlocked");
    send(4'b0110, 8'h00, 1'b1, "R2 program with pin high");
    send(4'b0011, 8'h00, 1'b0, "R8 unknown type");
    send(4'b1011, 8'h90, 1'b0, "R8 near-miss type");
    idle(1);
    chk(ack_ok, 1'b0, "R9 idle ack_ok");
    chk(wr_en, 1'b0, "R9 idle wr_en");
    send(4'b0110, 8'h00, 1'b0, "R5 program flag");
    send(4'b0110, 8'h00, 1'b0, "R6 second program");
    send(4'b0110, 8'h00, 1'b1, "R6 program pin high locked");
    send(4'b1010, 8'h00, 1'b0, "R3 locked addr 0");
    send(4'b1010, 8'h7F, 1'b0, "R3 locked addr 127");
    send(4'b1010, 8'h80, 1'b0, "R4 locked addr 128");
    send(4'b1010, 8'hFF, 1'b0, "R4 locked addr 255");
    send(4'b1010, 8'hC0, 1'b1, "R1 pin high locked");
    idle(1);

    rst_n = 1'b0;
    @(negedge clk);
    chk(prot_flag, 1'b1, "R7 flag kept through rst_n");
    chk(ack_ok, 1'b0, "R7 rst_n clears ack_ok");
    rst_n = 1'b1;
    send(4'b0110, 8'h00, 1'b0, "R6 program after rst_n");
    send(4'b1010, 8'h20, 1'b0, "R3 locked after rst_n");
    idle(1);

    por_init = 1'b1;
    @(negedge clk);
    por_init = 1'b0;
    flag_m = 1'b0;
    chk(prot_flag, 1'b0, "R7 por_init clears flag");
    send(4'b1010, 8'h20, 1'b0, "R4 writable after por");
    send(4'b0110, 8'h00, 1'b0, "R5 reprogram after por");
    idle(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule